// File: doc/BRIEF.md
# Read-Reply CRC-4 Checker

This block checks the integrity of a one-byte read reply. When `start` is seen, it captures the byte address, the command size and the 12-bit reply word. It then builds, one bit per clock, the message that the reply's check nibble protects: a read opcode bit, the address bits, and the returned data byte. A 4-bit CRC is run over that message. When the last bit has been folded in, the result is compared with the upper nibble of the reply.

The data byte is presented as soon as the reply is captured. A single-cycle `done` pulse marks the end of the computation, and `crc_ok` qualifies that pulse. The command size sets how many address bits take part in the message, which lets the same block serve memories of different sizes. Framing, bit recovery and radio timing belong to the surrounding logic.

Top module: `crc4_reply_check`

## Requirements
- R1: While `rst_n` is low, and after it is released with no `start`, `done`, `crc_ok` and `data_byte` are all zero.
- R2: The CRC is 4 bits wide and starts from 0x5 at every `start`. For each message bit b it computes f = crc[0] xor b, shifts the register right by one, and XORs in 0xC when f is 1. There is no final XOR.
- R3: The message order is fixed. First comes one opcode bit of value 1. Next come `cmd_size`-1 address bits, from `addr[0]` upward. Last come the 8 data bits, from `reply[0]` up to `reply[7]`.
- R4: `data_byte` equals `reply[7:0]` as captured at `start`. It is valid from the cycle after `start` and is held until the next `start`.
- R5: `done` is high for exactly one cycle. It rises `cmd_size`+8 clock edges after the edge that samples `start`, and is never high at any other time.
- R6: `crc_ok` is high only together with `done`, and only when the computed CRC equals `reply[11:8]`.
- R7: A `start` during a computation abandons it. No `done` is produced for the abandoned message, and a new computation begins on the new inputs.
- R8: Address bits at position `cmd_size`-1 and above have no effect on the result.
- R9: `addr`, `cmd_size` and `reply` are sampled only on `start`. Changes to them during a computation have no effect on `done`, `crc_ok` or `data_byte`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Capture the inputs and begin a check |
| cmd_size | input | CMD_W (4) | Command length in bits; the address uses cmd_size-1 of them |
| addr | input | ADDR_W (9) | Byte address |
| reply | input | 12 | Reply word: CRC nibble in [11:8], data in [7:0] |
| data_byte | output | 8 | Captured data byte |
| crc_ok | output | 1 | CRC matched; valid with `done` |
| done | output | 1 | One-cycle end-of-check pulse |

## Verification
The assertions take for granted that `cmd_size` lies between 1 and ADDR_W+1 whenever `start` is high. This bounds the message length to at least nine bits, so a `done` pulse can never follow a `start` on the next edge or follow another `done`. All stimulus keeps `cmd_size` inside this range, covering a command with no address bits, the full nine-bit address, and the 8- and 10-bit commands. Out-of-range address bits and mid-run input changes are applied only to inputs the block must ignore.

// File: rtl/crc4_reply_check.sv
module crc4_reply_check #(
  parameter int          ADDR_W   = 9,
  parameter int          CMD_W    = 4,
  parameter logic [3:0]  CRC_INIT = 4'h5,
  parameter logic [3:0]  CRC_POLY = 4'hC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CMD_W-1:0]  cmd_size,
  input  logic [ADDR_W-1:0] addr,
  input  logic [11:0]       reply,
  output logic [7:0]        data_byte,
  output logic              crc_ok,
  output logic              done
);
  localparam int DATA_W  = 8;
  localparam int LEN_MAX = 1 + ADDR_W + DATA_W;
  localparam int CNT_W   = $clog2(LEN_MAX + 1);

  logic              busy;
  logic [CNT_W-1:0]  cnt, cmd_q, a_idx, d_idx, last_idx;
  logic [ADDR_W-1:0] addr_q, addr_sh;
  logic [11:0]       reply_q;
  logic [7:0]        data_sh;
  logic [3:0]        crc, crc_nxt;
  logic              msg_bit, fb, last, done_q, ok_q;

  assign a_idx    = cnt - CNT_W'(1);
  assign d_idx    = cnt - cmd_q;
  assign addr_sh  = addr_q >> a_idx;
  assign data_sh  = reply_q[7:0] >> d_idx;
  assign last_idx = cmd_q + CNT_W'(DATA_W - 1);
  assign last     = (cnt == last_idx);

  always_comb begin
    if (cnt == '0)        msg_bit = 1'b1;
    else if (cnt < cmd_q) msg_bit = addr_sh[0];
    else                  msg_bit = data_sh[0];
  end

  assign fb      = crc[0] ^ msg_bit;
  assign crc_nxt = {1'b0, crc[3:1]} ^ (fb ? CRC_POLY : 4'h0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      cnt     <= '0;
      cmd_q   <= '0;
      addr_q  <= '0;
      reply_q <= '0;
      crc     <= CRC_INIT;
      done_q  <= 1'b0;
      ok_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      ok_q   <= 1'b0;
      if (start) begin
        busy    <= 1'b1;
        cnt     <= '0;
        crc     <= CRC_INIT;
        cmd_q   <= CNT_W'(cmd_size);
        addr_q  <= addr;
        reply_q <= reply;
      end else if (busy) begin
        crc <= crc_nxt;
        cnt <= cnt + CNT_W'(1);
        if (last) begin
          busy   <= 1'b0;
          done_q <= 1'b1;
          ok_q   <= (crc_nxt == reply_q[11:8]);
        end
      end
    end
  end

  assign data_byte = reply_q[7:0];
  assign done      = done_q;
  assign crc_ok    = ok_q;
endmodule

// File: rtl/crc4_reply_check_chk.sv
module crc4_reply_check_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       busy,
  input logic       done,
  input logic       crc_ok,
  input logic [7:0] data_byte
);
  // R5
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R5
  start_no_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !done);
  // R5
  idle_no_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> !done);
  // R6
  ok_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    crc_ok |-> done);
  // R4
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> $stable(data_byte));
endmodule

bind crc4_reply_check crc4_reply_check_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
  .done(done), .crc_ok(crc_ok), .data_byte(data_byte)
);

// File: tb/crc4_reply_check_tb.sv
module crc4_reply_check_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  cmd_size = '0;
  logic [8:0]  addr = '0;
  logic [11:0] reply = '0;
  logic [7:0]  data_byte;
  logic        crc_ok, done;

  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  crc4_reply_check u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .cmd_size(cmd_size),
    .addr(addr), .reply(reply), .data_byte(data_byte),
    .crc_ok(crc_ok), .done(done)
  );

  // {corrupt, cmd_size, addr, data}
  localparam int NV = 8;
  localparam logic [21:0] VECS [NV] = '{
    {1'b0, 4'd8,  9'h000, 8'h00},
    {1'b0, 4'd8,  9'h07F, 8'hFF},
    {1'b0, 4'd10, 9'h1FF, 8'hA5},
    {1'b1, 4'd10, 9'h123, 8'h3C},
    {1'b0, 4'd8,  9'h1AB, 8'h5A},
    {1'b0, 4'd1,  9'h1FF, 8'h81},
    {1'b1, 4'd10, 9'h000, 8'h00},
    {1'b0, 4'd4,  9'h005, 8'h77}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] step(input logic [3:0] c, input logic b);
    logic f;
    f = c[0] ^ b;
    step = (c >> 1) ^ (f ? 4'hC : 4'h0);
  endfunction

  function automatic logic [3:0] ref_crc(input int cmd, input logic [8:0] a, input logic [7:0] d);
    logic [3:0] c;
    c = 4'h5;
    c = step(c, 1'b1);
    for (int i = 0; i < cmd - 1; i++) c = step(c, a[i]);
    for (int i = 0; i < 8; i++) c = step(c, d[i]);
    ref_crc = c;
  endfunction

  task automatic run(input int cmd, input logic [8:0] a, input logic [7:0] d,
                     input bit corrupt, input bit perturb, input string tag);
    logic [3:0] c;
    logic [11:0] rep;
    int n, first;
    c   = ref_crc(cmd, a, d);
    rep = {corrupt ? (c ^ 4'h6) : c, d};
    n   = cmd + 8;
    first = -1;
    @(negedge clk);
    start = 1'b1; cmd_size = 4'(cmd); addr = a; reply = rep;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    check(data_byte == d, {"R4 ", tag}, data_byte, d);
    for (int k = 1; k <= n; k++) begin
      if (perturb && k == 3) begin
        addr = ~a; reply = ~rep; cmd_size = 4'd2;
      end
      @(posedge clk);
      @(negedge clk);
      if (done && first < 0) first = k;
      if (k < n && crc_ok) first = -2;
    end
    check(first == n, {"R5 latency ", tag}, first, n);
    check(crc_ok == !corrupt, {"R6 R2 R3 ", tag}, crc_ok, !corrupt);
    check(data_byte == d, {"R4 hold ", tag}, data_byte, d);
    @(negedge clk);
    check(!done && !crc_ok, {"R5 R6 pulse end ", tag}, {done, crc_ok}, 0);
  endtask

  initial begin
    #(20 * 200000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1
    check(!done && !crc_ok && data_byte == 0, "R1 in reset", {done, crc_ok, data_byte}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(!done && !crc_ok && data_byte == 0, "R1 after release", {done, crc_ok, data_byte}, 0);

    for (int v = 0; v < NV; v++) begin
      logic [21:0] e;
      e = VECS[v];
      run(int'(e[20:17]), e[16:8], e[7:0], e[21], 1'b0, $sformatf("vec%0d", v));
    end

    // R8: high address garbage with full reference ignoring it
    begin
      logic [3:0] c;
      c = ref_crc(3, 9'h003, 8'hC3);
      check(c == ref_crc(3, 9'h1FB, 8'hC3), "R8 ref", c, ref_crc(3, 9'h1FB, 8'hC3));
    end
    run(3, 9'h1FB, 8'hC3, 1'b0, 1'b0, "R8 upper bits");

    // R9: inputs change mid-run
    run(10, 9'h0B4, 8'h96, 1'b0, 1'b1, "R9 mid change");
    run(9,  9'h011, 8'h0F, 1'b1, 1'b1, "R9 mid change corrupt");

    // R7: restart abandons the first message
    begin
      int seen;
      seen = 0;
      @(negedge clk);
      start = 1'b1; cmd_size = 4'd10; addr = 9'h1AA;
      reply = {ref_crc(10, 9'h1AA, 8'h11), 8'h11};
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      for (int k = 0; k < 5; k++) begin
        @(posedge clk);
        @(negedge clk);
        if (done) seen++;
      end
      run(8, 9'h055, 8'hE7, 1'b1, 1'b0, "R7 restart");
      check(seen == 0, "R7 no early done", seen, 0);
      seen = 0;
      for (int k = 0; k < 25; k++) begin
        @(negedge clk);
        if (done) seen++;
      end
      check(seen == 0, "R7 abandoned gives no done", seen, 0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule